// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block moves data between two parallel buses, A and B, with one storage element in each direction. Each storage element can act as a transparent latch or as an edge-triggered register. Each direction has its own group of four controls: an active-low output enable, a latch enable, a port clock and an active-low clock enable. All channels of one direction share that direction's controls. Bus width is a parameter and defaults to 18 channels.

The whole block runs on one free-running system clock. The port clocks and latch enables are asynchronous to it, so each passes through a two-stage synchronizer. A port-clock rising edge is detected as a 0-then-1 change in the synchronized value. The three-state outputs are modelled as a data vector plus a drive flag for each side. A wrapper at the chip pads can join each data vector and its drive flag into a real inout pin. The block also raises a clash flag when both sides drive at the same time, so that such a wrapper can report the contention.

Top module: `ubt_xcvr`

## Requirements
- R1: While a direction's synchronized latch enable is high, that direction's output equals its input bus combinationally. The latch enable takes effect two system-clock edges after it rises.
- R2: With the latch enable low and the clock enable low (0), a rising edge of the port clock loads the input bus into the stored value. The loaded value appears on the output three system-clock edges after the port clock rises.
- R3: With the latch enable low and the port clock held steady at either level, the output keeps the stored value whatever the input bus does.
- R4: With the latch enable low and the clock enable high (1), a rising edge of the port clock leaves the stored value unchanged.
- R5: While the output enable is high (1), the drive flag is 0 and the output data is all zeros. While it is low (0), the drive flag is 1 and the output carries the transparent or stored value.
- R6: When the latch enable falls, the value on the input bus during transparency is kept as the stored value.
- R7: A synchronous active-high reset clears both stored values to zero. Reset does not affect the drive flags, which still follow the output enables.
- R8: The B-to-A path (input on bus B, output on side A) behaves like the A-to-B path, using its own four controls. Activity in one direction never changes the other direction's output.
- R9: The clash output is 1 exactly when both drive flags are 1.
- R10: A falling edge of the port clock never loads the stored value, whatever the clock enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Bus A data in (source for A-to-B) |
| b_in | input | W | Bus B data in (source for B-to-A) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_pclk | input | 1 | A-to-B port clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_pclk | input | 1 | B-to-A port clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | W | Data driven toward bus B |
| b_drive | output | 1 | Side B driver active |
| a_out | output | W | Data driven toward bus A |
| a_drive | output | 1 | Side A driver active |
| clash | output | 1 | Both sides driving at once |

## Verification
The output enable acts with no delay, so drive flags and zeroed data can be checked in the same cycle. The latch enable passes through two synchronizer stages, so transparency starts, and the fall is captured, two edges after the change. A port-clock rise needs a third edge, for edge detection and the register load, before the output shows the new value. The bench changes every input just after a falling clock edge and then waits four full cycles before sampling. It also holds data and clock enable stable across that whole window, so every result it compares is already settled, whichever of these latencies applies.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int NUM_DIRS = 2;

    typedef enum logic [0:0] {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } dir_e;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic pclk;
        logic ce_n;
    } dir_ctl_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_FOLLOW = 2'd1,
        ACT_EDGE   = 2'd2
    } store_act_e;

    function automatic store_act_e pick_action(input logic le_on,
                                               input logic rise,
                                               input logic ce_n);
        if (le_on)
            return ACT_FOLLOW;
        else if (rise && !ce_n)
            return ACT_EDGE;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/ubt_sync.sv
module ubt_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain[0] <= '0;
        else
            chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else
                chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int W          = 18,
    parameter int SYNC_STAGE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  dir_ctl_t     ctl,
    output logic [W-1:0] dout,
    output logic         drive,
    output logic [W-1:0] held_o,
    output logic         le_on_o,
    output logic         rise_o
);
    localparam int CTL_BITS = 2;

    logic [CTL_BITS-1:0] ctl_raw;
    logic [CTL_BITS-1:0] ctl_s;
    logic                le_on;
    logic                pclk_s;
    logic                pclk_d;
    logic                rise;
    logic [W-1:0]        store_q;
    store_act_e          act;

    assign ctl_raw = {ctl.le, ctl.pclk};

    ubt_sync #(.STAGES(SYNC_STAGE), .WIDTH(CTL_BITS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ctl_raw),
        .sync_out (ctl_s)
    );

    assign le_on  = ctl_s[1];
    assign pclk_s = ctl_s[0];

    always_ff @(posedge clk) begin
        if (rst)
            pclk_d <= 1'b0;
        else
            pclk_d <= pclk_s;
    end

    assign rise = pclk_s & ~pclk_d;
    assign act  = pick_action(le_on, rise, ctl.ce_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            case (act)
                ACT_FOLLOW: store_q <= din;
                ACT_EDGE:   store_q <= din;
                default:    store_q <= store_q;
            endcase
        end
    end

    assign drive   = ~ctl.oe_n;
    assign dout    = drive ? (le_on ? din : store_q) : '0;
    assign held_o  = store_q;
    assign le_on_o = le_on;
    assign rise_o  = rise;
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int W          = 18,
    parameter int SYNC_STAGE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_pclk,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_pclk,
    input  logic         ba_ce_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic         clash
);
    dir_ctl_t [NUM_DIRS-1:0]        ctl_v;
    logic     [NUM_DIRS-1:0][W-1:0] din_v;
    logic     [NUM_DIRS-1:0][W-1:0] dout_v;
    logic     [NUM_DIRS-1:0][W-1:0] held_v;
    logic     [NUM_DIRS-1:0]        drive_v;
    logic     [NUM_DIRS-1:0]        le_on_v;
    logic     [NUM_DIRS-1:0]        rise_v;
    logic     [NUM_DIRS-1:0]        oe_n_v;
    logic     [NUM_DIRS-1:0]        ce_n_v;

    assign din_v[DIR_AB] = a_in;
    assign din_v[DIR_BA] = b_in;
    assign ctl_v[DIR_AB] = '{oe_n: ab_oe_n, le: ab_le, pclk: ab_pclk, ce_n: ab_ce_n};
    assign ctl_v[DIR_BA] = '{oe_n: ba_oe_n, le: ba_le, pclk: ba_pclk, ce_n: ba_ce_n};

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        ubt_lane #(.W(W), .SYNC_STAGE(SYNC_STAGE)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .din     (din_v[d]),
            .ctl     (ctl_v[d]),
            .dout    (dout_v[d]),
            .drive   (drive_v[d]),
            .held_o  (held_v[d]),
            .le_on_o (le_on_v[d]),
            .rise_o  (rise_v[d])
        );
        assign oe_n_v[d] = ctl_v[d].oe_n;
        assign ce_n_v[d] = ctl_v[d].ce_n;
    end

    assign b_out   = dout_v[DIR_AB];
    assign b_drive = drive_v[DIR_AB];
    assign a_out   = dout_v[DIR_BA];
    assign a_drive = drive_v[DIR_BA];
    assign clash   = a_drive & b_drive;
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk
    import ubt_pkg::*;
#(
    parameter int W = 18
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_DIRS-1:0][W-1:0]  din,
    input logic [NUM_DIRS-1:0][W-1:0]  dout,
    input logic [NUM_DIRS-1:0][W-1:0]  held,
    input logic [NUM_DIRS-1:0]         drive,
    input logic [NUM_DIRS-1:0]         le_on,
    input logic [NUM_DIRS-1:0]         rise,
    input logic [NUM_DIRS-1:0]         oe_n,
    input logic [NUM_DIRS-1:0]         ce_n,
    input logic                        clash
);
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_chk
        // R1, R8: transparent path follows the input of its own direction
        p_follow_r1: assert property (@(posedge clk) disable iff (rst)
            le_on[d] && !oe_n[d] |-> dout[d] == din[d]);
        // R2: enabled port-clock rise loads the input
        p_load_r2: assert property (@(posedge clk) disable iff (rst)
            !le_on[d] && rise[d] && !ce_n[d] |=> held[d] == $past(din[d]));
        // R3, R10: no rise and no transparency keeps the stored value
        p_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !le_on[d] && !rise[d] |=> $stable(held[d]));
        // R4: disabled clock never loads
        p_block_r4: assert property (@(posedge clk) disable iff (rst)
            !le_on[d] && ce_n[d] |=> $stable(held[d]));
        // R5: disabled side is quiet
        p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            oe_n[d] |-> !drive[d] && dout[d] == '0);
        // R6: latch-enable fall keeps the transparent value
        p_retain_r6: assert property (@(posedge clk) disable iff (rst)
            $fell(le_on[d]) |-> held[d] == $past(din[d]));
        // R7: reset clears storage
        p_clear_r7: assert property (@(posedge clk)
            rst |=> held[d] == '0);
        // R7: reset leaves drive flags to the enables
        p_drive_r7: assert property (@(posedge clk)
            rst && !oe_n[d] |-> drive[d]);
    end

    // R9: clash flag tracks the two drivers
    p_clash_r9: assert property (@(posedge clk) disable iff (rst)
        clash == (drive[0] && drive[1]));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din_v),
    .dout  (dout_v),
    .held  (held_v),
    .drive (drive_v),
    .le_on (le_on_v),
    .rise  (rise_v),
    .oe_n  (oe_n_v),
    .ce_n  (ce_n_v),
    .clash (clash)
);

// File: tb/tb_ubt_xcvr.sv
module tb_ubt_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din   [2];
    logic [1:0]   oe_n, le, pk, ce_n;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive, clash;
    logic [W-1:0] held_m [2];
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #5 clk = ~clk;

    ubt_xcvr #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(din[0]), .b_in(din[1]),
        .ab_oe_n(oe_n[0]), .ab_le(le[0]), .ab_pclk(pk[0]), .ab_ce_n(ce_n[0]),
        .ba_oe_n(oe_n[1]), .ba_le(le[1]), .ba_pclk(pk[1]), .ba_ce_n(ce_n[1]),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
        .clash(clash)
    );

    function automatic logic [W-1:0] exp_out(int d);
        if (oe_n[d]) return '0;
        return le[d] ? din[d] : held_m[d];
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_dir(int d, string req);
        logic [W-1:0] got;
        logic         gdrv;
        got  = (d == 0) ? b_out : a_out;
        gdrv = (d == 0) ? b_drive : a_drive;
        checks++;
        if (got !== exp_out(d) || gdrv !== ~oe_n[d]) begin
            errors++;
            $display("FAIL %s dir%0d: got %h drive %b, expected %h drive %b",
                     req, d, got, gdrv, exp_out(d), ~oe_n[d]);
        end
    endtask

    task automatic check_all(int d, string req);
        check_dir(d, req);
        check_dir(1 - d, "R8");
        checks++;
        if (clash !== (~oe_n[0] & ~oe_n[1])) begin
            errors++;
            $display("FAIL R9: clash got %b expected %b", clash, ~oe_n[0] & ~oe_n[1]);
        end
    endtask

    task automatic do_transparent(int d, logic [W-1:0] x);
        le[d] = 1'b1; din[d] = x;
        settle(); check_all(d, "R1");
        held_m[d] = x;
        le[d] = 1'b0;
        settle(); check_all(d, "R6");
        din[d] = W'($urandom);
        settle(); check_all(d, "R6");
    endtask

    task automatic do_clock(int d, logic [W-1:0] x, logic ce);
        din[d] = x; ce_n[d] = ce;
        settle(); check_all(d, "R3");
        pk[d] = 1'b1;
        settle();
        if (!ce) held_m[d] = x;
        check_all(d, ce ? "R4" : "R2");
        pk[d] = 1'b0;
        settle(); check_all(d, "R3");
    endtask

    task automatic do_fall(int d);
        ce_n[d] = 1'b1; pk[d] = 1'b1;
        settle();
        din[d] = W'($urandom); ce_n[d] = 1'b0; pk[d] = 1'b0;
        settle(); check_all(d, "R10");
    endtask

    task automatic do_oe(int d, logic v);
        oe_n[d] = v;
        @(negedge clk); check_all(d, "R5");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1187));
        din[0] = '0; din[1] = '0;
        oe_n = 2'b00; le = 2'b00; pk = 2'b00; ce_n = 2'b11;
        held_m[0] = '0; held_m[1] = '0;
        din[0] = W'(18'h2aaaa); din[1] = W'(18'h15555);
        repeat (3) @(negedge clk);
        // R7: storage cleared, drive flags follow enables during reset
        check_all(0, "R7"); check_all(1, "R7");
        rst = 1'b0;
        settle(); check_all(0, "R7"); check_all(1, "R7");

        // directed corner cases
        do_transparent(0, W'(18'h3ffff));
        do_transparent(1, W'(18'h00001));
        do_clock(0, W'(18'h12345), 1'b0);
        do_clock(0, W'(18'h0f0f0), 1'b1);
        do_clock(1, W'(18'h20202), 1'b0);
        do_fall(0);
        do_fall(1);
        do_oe(0, 1'b1);
        do_clock(0, W'(18'h11111), 1'b0);
        do_oe(0, 1'b0);
        do_oe(1, 1'b1);
        do_oe(1, 1'b0);

        // mid-run reset with both drivers on
        rst = 1'b1;
        settle();
        held_m[0] = '0; held_m[1] = '0;
        check_all(0, "R7"); check_all(1, "R7");
        rst = 1'b0;
        settle(); check_all(0, "R7");

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int d;
            int op;
            d  = int'($urandom % 2);
            op = int'($urandom % 5);
            case (op)
                0: do_transparent(d, W'($urandom));
                1: do_clock(d, W'($urandom), 1'b0);
                2: do_clock(d, W'($urandom), 1'($urandom));
                3: do_fall(d);
                default: do_oe(d, 1'($urandom));
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule